// File: doc/BRIEF.md
# Register-Mapped Pin Controller with SD Pin Routing

This block controls 54 general-purpose pins from a 32-bit register bus with a 12-bit byte address. Each pin carries a 3-bit function code, and the codes are packed ten to a word across six function-select words. Software raises and lowers a latched per-pin level through separate write-one-to-set and write-one-to-clear words, and reads the level back through two read-only words. A pin whose function code is 1 (output) has its level driven on a registered output line.

The block also drives a single routing bit that decides which of two SD host controllers owns pins 48 to 53. The bit follows the function codes of those six pins: all zero selects controller A, all four selects controller B, and any mix keeps the previous choice. A window of word offsets holds registers that do nothing: they read zero and take no writes. Any other offset raises a one-cycle error pulse.

Requests are single-cycle. A write takes effect on the clock edge that accepts it. Read data and the error pulse appear in the following cycle.

Top module: `gpio_pinmux_ctrl`

## Requirements
- R1: After reset, every function code and every latched level is zero, `pin_out` is all zero, `sd_route` is 0 (controller A), and `rsp_rdata` and `bad_addr` are zero.
- R2: Function-select word n sits at byte offset 4n, for n from 0 to 5. Pin 10n+i uses bits 3i+2 down to 3i of that word. Bits 31:30 read as zero. Fields for pins numbered 54 and above are not stored and read as zero, so word 5 holds only pins 50 to 53 in bits 11:0.
- R3: The set words are at 0x1C (pins 0 to 31 in bits 31:0) and 0x20 (pins 32 to 53 in bits 21:0, upper bits ignored). The clear words are at 0x28 and 0x2C with the same split. A 1 bit sets, or clears, that pin's latched level. A 0 bit leaves it alone. All four words read as zero.
- R4: Offset 0x34 returns the levels of pins 0 to 31. Offset 0x38 returns the levels of pins 32 to 53 in bits 21:0, with the upper bits zero. Writes to either offset change nothing.
- R5: A set or clear write changes a pin's `pin_out` bit only when two things hold: the write changes that pin's latched level, and the pin's code is 1 at that time. The change is visible in the cycle after the write. No other access changes `pin_out`.
- R6: The latched level updates whether or not the pin is an output. A pin that is not an output, or whose code changes, keeps its last driven `pin_out` value.
- R7: On a write to any function-select word, the new codes decide `sd_route`. If pins 48 to 53 all have code 0, it becomes 0. If they all have code 4, it becomes 1. Any other mix keeps the previous value. `sd_route` changes at no other time.
- R8: Every word-aligned offset from 0x40 to 0x9C reads as zero, ignores writes and raises no error.
- R9: An access to any other offset raises `bad_addr` for exactly the cycle after the request. This covers a non-zero value in bits 1:0, offsets 0x18, 0x24, 0x30 and 0x3C, and offsets above 0x9C. Such a read returns zero and such a write changes nothing.
- R10: Read data appears on `rsp_rdata` in the cycle after the read request. In a cycle that follows no read, `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| bad_addr | output | 1 | One-cycle pulse after an access to an undecoded offset |
| pin_out | output | 54 | Driven value of each pin |
| sd_route | output | 1 | SD pin owner: 0 for controller A, 1 for controller B |

## Verification
The assertions check the timing rules on every cycle. `pin_out` moves only after a set or clear write, and a set write never lowers a bit. `sd_route` moves only after a function-select write. `bad_addr` and `rsp_rdata` stay quiet when no request or read came before, and the inert window never raises an error. Only the bench scenarios can show the data-dependent rules. These include the packing and truncation of function fields and the split of the upper set and clear words. They also include a set to a level that is already high leaving an output unchanged, a level latched while a pin was an input, and the hold of the SD routing bit across mixed codes.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_FSEL,
    ACC_SET_LO,
    ACC_SET_HI,
    ACC_CLR_LO,
    ACC_CLR_HI,
    ACC_LEV_LO,
    ACC_LEV_HI,
    ACC_INERT,
    ACC_BAD
  } acc_kind_e;

  localparam logic [11:0] OFS_SET_LO  = 12'h01C;
  localparam logic [11:0] OFS_SET_HI  = 12'h020;
  localparam logic [11:0] OFS_CLR_LO  = 12'h028;
  localparam logic [11:0] OFS_CLR_HI  = 12'h02C;
  localparam logic [11:0] OFS_LEV_LO  = 12'h034;
  localparam logic [11:0] OFS_LEV_HI  = 12'h038;
  localparam logic [11:0] OFS_INERT_LO = 12'h040;
  localparam logic [11:0] OFS_INERT_HI = 12'h09C;

  localparam int FN_CODE_OUT  = 1;
  localparam int FN_CODE_SD_A = 0;
  localparam int FN_CODE_SD_B = 4;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_pinmux_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int FSEL_REGS = 6,
  parameter int IDX_W     = $clog2(FSEL_REGS)
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  fsel_idx
);

  localparam logic [ADDR_W-1:0] FSEL_END = ADDR_W'(FSEL_REGS * 4);

  assign fsel_idx = addr[IDX_W+1:2];

  always_comb begin
    if (!valid) begin
      kind = ACC_NONE;
    end else if (addr[1:0] != 2'b00) begin
      kind = ACC_BAD;
    end else if (addr < FSEL_END) begin
      kind = ACC_FSEL;
    end else begin
      case (addr)
        ADDR_W'(OFS_SET_LO): kind = ACC_SET_LO;
        ADDR_W'(OFS_SET_HI): kind = ACC_SET_HI;
        ADDR_W'(OFS_CLR_LO): kind = ACC_CLR_LO;
        ADDR_W'(OFS_CLR_HI): kind = ACC_CLR_HI;
        ADDR_W'(OFS_LEV_LO): kind = ACC_LEV_LO;
        ADDR_W'(OFS_LEV_HI): kind = ACC_LEV_HI;
        default: begin
          if (addr >= ADDR_W'(OFS_INERT_LO) && addr <= ADDR_W'(OFS_INERT_HI))
            kind = ACC_INERT;
          else
            kind = ACC_BAD;
        end
      endcase
    end
  end

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank #(
  parameter int NUM_PINS  = 54,
  parameter int FN_W      = 3,
  parameter int PER_WORD  = 10,
  parameter int FSEL_REGS = 6,
  parameter int IDX_W     = 3,
  parameter int WIN_LO    = 48,
  parameter int WIN_N     = 6,
  localparam int FIELD_W  = PER_WORD * FN_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [FIELD_W-1:0]        wr_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [FIELD_W-1:0]        rd_word,
  output logic [NUM_PINS*FN_W-1:0]  codes,
  output logic [WIN_N*FN_W-1:0]     win_next
);

  logic [FN_W-1:0] code_q [NUM_PINS];
  logic [FN_W-1:0] code_d [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int REG  = p / PER_WORD;
    localparam int SLOT = p % PER_WORD;

    always_comb begin
      code_d[p] = code_q[p];
      if (wr_en && (wr_idx == IDX_W'(REG)))
        code_d[p] = wr_data[SLOT*FN_W +: FN_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[p] <= '0;
      else
        code_q[p] <= code_d[p];
    end

    assign codes[p*FN_W +: FN_W] = code_q[p];
  end

  for (genvar w = 0; w < WIN_N; w++) begin : g_win
    assign win_next[w*FN_W +: FN_W] = code_d[WIN_LO + w];
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (int'(rd_idx) == p / PER_WORD)
        rd_word[(p % PER_WORD)*FN_W +: FN_W] = code_q[p];
    end
  end

endmodule

// File: rtl/gpio_level_drive.sv
module gpio_level_drive #(
  parameter int NUM_PINS = 54,
  parameter int FN_W     = 3,
  parameter int OUT_CODE = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic                     clr_en,
  input  logic [NUM_PINS-1:0]      mask,
  input  logic [NUM_PINS*FN_W-1:0] codes,
  output logic [NUM_PINS-1:0]      level,
  output logic [NUM_PINS-1:0]      pin_out
);

  logic [NUM_PINS-1:0] level_d;
  logic [NUM_PINS-1:0] pin_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic is_out;
    assign is_out = (codes[p*FN_W +: FN_W] == FN_W'(OUT_CODE));

    always_comb begin
      level_d[p] = level[p];
      pin_d[p]   = pin_out[p];
      if (set_en && mask[p]) begin
        level_d[p] = 1'b1;
        if (!level[p] && is_out) pin_d[p] = 1'b1;
      end else if (clr_en && mask[p]) begin
        level_d[p] = 1'b0;
        if (level[p] && is_out) pin_d[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      pin_out <= '0;
    end else if (set_en || clr_en) begin
      level   <= level_d;
      pin_out <= pin_d;
    end
  end

endmodule

// File: rtl/gpio_sd_route.sv
module gpio_sd_route #(
  parameter int FN_W   = 3,
  parameter int WIN_N  = 6,
  parameter int CODE_A = 0,
  parameter int CODE_B = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic [WIN_N*FN_W-1:0] win_next,
  output logic                  sel_b
);

  logic all_a;
  logic all_b;
  logic sel_d;

  always_comb begin
    all_a = 1'b1;
    all_b = 1'b1;
    for (int w = 0; w < WIN_N; w++) begin
      if (win_next[w*FN_W +: FN_W] != FN_W'(CODE_A)) all_a = 1'b0;
      if (win_next[w*FN_W +: FN_W] != FN_W'(CODE_B)) all_b = 1'b0;
    end
    sel_d = sel_b;
    if (all_a)      sel_d = 1'b0;
    else if (all_b) sel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_b <= 1'b0;
    else if (upd)
      sel_b <= sel_d;
  end

endmodule

// File: rtl/gpio_pinmux_ctrl.sv
module gpio_pinmux_ctrl
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int FN_W     = 3,
  parameter int PER_WORD = 10,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int SD_FIRST = 48,
  parameter int SD_COUNT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                bad_addr,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                sd_route
);

  localparam int FSEL_REGS = (NUM_PINS + PER_WORD - 1) / PER_WORD;
  localparam int IDX_W     = $clog2(FSEL_REGS);
  localparam int FIELD_W   = PER_WORD * FN_W;
  localparam int HI_W      = NUM_PINS - DATA_W;

  acc_kind_e                 kind;
  logic [IDX_W-1:0]          fsel_idx;
  logic [FIELD_W-1:0]        fsel_rd;
  logic [NUM_PINS*FN_W-1:0]  codes;
  logic [SD_COUNT*FN_W-1:0]  win_next;
  logic [NUM_PINS-1:0]       level;
  logic [NUM_PINS-1:0]       mask;
  logic                      wr, rd;
  logic                      fsel_we, set_we, clr_we;
  logic [DATA_W-1:0]         rd_val, rdata_d;

  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;
  assign fsel_we = wr && (kind == ACC_FSEL);
  assign set_we  = wr && (kind == ACC_SET_LO || kind == ACC_SET_HI);
  assign clr_we  = wr && (kind == ACC_CLR_LO || kind == ACC_CLR_HI);

  always_comb begin
    if (kind == ACC_SET_HI || kind == ACC_CLR_HI)
      mask = {req_wdata[HI_W-1:0], {DATA_W{1'b0}}};
    else
      mask = {{HI_W{1'b0}}, req_wdata};
  end

  gpio_reg_decode #(
    .ADDR_W(ADDR_W), .FSEL_REGS(FSEL_REGS), .IDX_W(IDX_W)
  ) u_decode (
    .valid(req_valid), .addr(req_addr), .kind(kind), .fsel_idx(fsel_idx)
  );

  gpio_fsel_bank #(
    .NUM_PINS(NUM_PINS), .FN_W(FN_W), .PER_WORD(PER_WORD),
    .FSEL_REGS(FSEL_REGS), .IDX_W(IDX_W),
    .WIN_LO(SD_FIRST), .WIN_N(SD_COUNT)
  ) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(fsel_we), .wr_idx(fsel_idx),
    .wr_data(req_wdata[FIELD_W-1:0]), .rd_idx(fsel_idx), .rd_word(fsel_rd),
    .codes(codes), .win_next(win_next)
  );

  gpio_level_drive #(
    .NUM_PINS(NUM_PINS), .FN_W(FN_W), .OUT_CODE(FN_CODE_OUT)
  ) u_level (
    .clk(clk), .rst_n(rst_n), .set_en(set_we), .clr_en(clr_we),
    .mask(mask), .codes(codes), .level(level), .pin_out(pin_out)
  );

  gpio_sd_route #(
    .FN_W(FN_W), .WIN_N(SD_COUNT),
    .CODE_A(FN_CODE_SD_A), .CODE_B(FN_CODE_SD_B)
  ) u_sd (
    .clk(clk), .rst_n(rst_n), .upd(fsel_we), .win_next(win_next), .sel_b(sd_route)
  );

  always_comb begin
    case (kind)
      ACC_FSEL:   rd_val = {{(DATA_W-FIELD_W){1'b0}}, fsel_rd};
      ACC_LEV_LO: rd_val = level[DATA_W-1:0];
      ACC_LEV_HI: rd_val = {{(2*DATA_W-NUM_PINS){1'b0}}, level[NUM_PINS-1:DATA_W]};
      default:    rd_val = '0;
    endcase
    rdata_d = rd ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      bad_addr  <= 1'b0;
    end else begin
      rsp_rdata <= rdata_d;
      bad_addr  <= (kind == ACC_BAD);
    end
  end

endmodule

// File: rtl/gpio_pinmux_ctrl_chk.sv
module gpio_pinmux_ctrl_chk #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic                bad_addr,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                sd_route
);

  logic wr_any, set_wr, drive_wr, fsel_wr, inert_acc;

  assign wr_any    = req_valid && req_write;
  assign set_wr    = wr_any && (req_addr == ADDR_W'(12'h01C) || req_addr == ADDR_W'(12'h020));
  assign drive_wr  = set_wr || (wr_any && (req_addr == ADDR_W'(12'h028) ||
                                           req_addr == ADDR_W'(12'h02C)));
  assign fsel_wr   = wr_any && (req_addr < ADDR_W'(12'h018)) && (req_addr[1:0] == 2'b00);
  assign inert_acc = req_valid && (req_addr[1:0] == 2'b00) &&
                     (req_addr >= ADDR_W'(12'h040)) && (req_addr <= ADDR_W'(12'h09C));

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (rsp_rdata == '0)); // R10

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !bad_addr); // R9

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> (rsp_rdata == '0)); // R9

  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_wr |=> $stable(pin_out)); // R5

  AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (($past(pin_out) & ~pin_out) == '0)); // R5

  AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fsel_wr |=> $stable(sd_route)); // R7

  AST_INERT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    inert_acc |=> !bad_addr); // R8

endmodule

bind gpio_pinmux_ctrl gpio_pinmux_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_rdata(rsp_rdata), .bad_addr(bad_addr),
  .pin_out(pin_out), .sd_route(sd_route)
);

// File: tb/gpio_pinmux_ctrl_test.sv
module gpio_pinmux_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic        bad_addr;
  logic [NP-1:0] pin_out;
  logic        sd_route;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int m_code [NP];
  bit m_lev [NP];
  bit m_pin [NP];
  bit m_sd;
  logic [31:0] m_rd;
  bit m_err;
  string prev_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinmux_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .bad_addr(bad_addr), .pin_out(pin_out), .sd_route(sd_route)
  );

  // 0 fsel, 1 set lo, 2 set hi, 3 clr lo, 4 clr hi, 5 lev lo, 6 lev hi, 7 inert, 8 bad
  function automatic int classify(logic [11:0] a);
    if (a[1:0] != 0) return 8;
    if (a < 12'h018) return 0;
    if (a == 12'h01C) return 1;
    if (a == 12'h020) return 2;
    if (a == 12'h028) return 3;
    if (a == 12'h02C) return 4;
    if (a == 12'h034) return 5;
    if (a == 12'h038) return 6;
    if (a >= 12'h040 && a <= 12'h09C) return 7;
    return 8;
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", prev_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NP-1:0] ep;
    for (int p = 0; p < NP; p++) ep[p] = m_pin[p];
    check("rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
    check("bad_addr", 64'(bad_addr), 64'(m_err));
    check("pin_out", 64'(pin_out), 64'(ep));
    check("sd_route", 64'(sd_route), 64'(m_sd));
  endtask

  task automatic model_step(bit v, bit w, logic [11:0] a, logic [31:0] d);
    int k;
    logic [31:0] r;
    k = classify(a);
    r = 0;
    m_err = v && (k == 8);
    if (v && !w) begin
      if (k == 0) begin
        for (int i = 0; i < 10; i++)
          if (a/4*10 + i < NP) r |= 32'(m_code[a/4*10 + i]) << (3*i);
      end else if (k == 5) begin
        for (int i = 0; i < 32; i++) r[i] = m_lev[i];
      end else if (k == 6) begin
        for (int i = 0; i < NP-32; i++) r[i] = m_lev[32+i];
      end
    end
    m_rd = r;
    if (v && w) begin
      if (k == 0) begin
        bit alla, allb;
        for (int i = 0; i < 10; i++)
          if (a/4*10 + i < NP) m_code[a/4*10 + i] = int'((d >> (3*i)) & 7);
        alla = 1; allb = 1;
        for (int p = 48; p < 54; p++) begin
          if (m_code[p] != 0) alla = 0;
          if (m_code[p] != 4) allb = 0;
        end
        if (alla) m_sd = 0;
        else if (allb) m_sd = 1;
      end else if (k >= 1 && k <= 4) begin
        int base = (k == 2 || k == 4) ? 32 : 0;
        int cnt  = (base == 32) ? NP - 32 : 32;
        bit is_set = (k <= 2);
        for (int i = 0; i < cnt; i++) begin
          if (d[i]) begin
            int p = base + i;
            if (is_set) begin
              if (!m_lev[p] && m_code[p] == 1) m_pin[p] = 1;
              m_lev[p] = 1;
            end else begin
              if (m_lev[p] && m_code[p] == 1) m_pin[p] = 0;
              m_lev[p] = 0;
            end
          end
        end
      end
    end
  endtask

  task automatic do_op(bit v, bit w, logic [11:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    compare_all();
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    model_step(v, w, a, d);
    prev_tag = tag;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    do_op(1, 1, a, d, tag);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    do_op(1, 0, a, 0, tag);
  endtask

  task automatic idle(string tag);
    do_op(0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    for (int p = 0; p < NP; p++) begin m_code[p] = 0; m_lev[p] = 0; m_pin[p] = 0; end
    m_sd = 0; m_rd = 0; m_err = 0; prev_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    idle("R1");
    rd(12'h000, "R1");
    rd(12'h034, "R1");
    rd(12'h038, "R1");

    // R2 packing and truncation
    wr(12'h000, 32'hFFFF_FFFF, "R2");
    rd(12'h000, "R2");
    wr(12'h014, 32'hFFFF_FFFF, "R2");
    rd(12'h014, "R2");
    wr(12'h008, 32'h1234_5678, "R2");
    rd(12'h008, "R2");
    rd(12'h00C, "R2");

    // R3 / R4 level words
    wr(12'h000, 32'h0, "R3");
    wr(12'h01C, 32'h8000_0021, "R3");
    rd(12'h034, "R3");
    rd(12'h01C, "R3");
    wr(12'h028, 32'h0000_0001, "R3");
    rd(12'h034, "R3");
    wr(12'h020, 32'hFFC0_0001, "R3");
    rd(12'h038, "R3");
    rd(12'h02C, "R3");
    wr(12'h02C, 32'hFFFF_FFFF, "R3");
    rd(12'h038, "R4");
    wr(12'h034, 32'hFFFF_FFFF, "R4");
    wr(12'h038, 32'hFFFF_FFFF, "R4");
    rd(12'h034, "R4");
    rd(12'h038, "R4");

    // R5 output driving
    wr(12'h028, 32'hFFFF_FFFF, "R5");
    wr(12'h000, 32'h0000_0200, "R5");
    wr(12'h01C, 32'h0000_0008, "R5");
    wr(12'h01C, 32'h0000_0020, "R6");
    wr(12'h000, 32'h0000_8200, "R5");
    wr(12'h01C, 32'h0000_0020, "R5");
    wr(12'h028, 32'h0000_0020, "R5");
    wr(12'h01C, 32'h0000_0020, "R5");
    wr(12'h028, 32'h0000_0008, "R5");

    // R6 non-output pins hold
    wr(12'h000, 32'h0, "R6");
    wr(12'h028, 32'h0000_0020, "R6");
    rd(12'h034, "R6");
    wr(12'h01C, 32'h0000_0020, "R6");

    // upper pins
    wr(12'h014, 32'h0000_0001, "R5");
    wr(12'h020, 32'h0004_0000, "R5");
    wr(12'h02C, 32'h0004_0000, "R5");
    wr(12'h020, 32'h0004_0000, "R5");

    // R7 SD routing
    wr(12'h014, 32'h0, "R7");
    wr(12'h010, 32'h2400_0000, "R7");
    wr(12'h014, 32'h0000_0924, "R7");
    rd(12'h010, "R7");
    wr(12'h014, 32'h0000_0924, "R7");
    wr(12'h010, 32'h0, "R7");
    wr(12'h010, 32'h2400_0000, "R7");
    wr(12'h010, 32'h0100_0000, "R7");
    wr(12'h014, 32'h0, "R7");
    wr(12'h010, 32'h0, "R7");

    // R8 inert window
    wr(12'h040, 32'hFFFF_FFFF, "R8");
    rd(12'h040, "R8");
    rd(12'h09C, "R8");
    wr(12'h094, 32'hFFFF_FFFF, "R8");
    rd(12'h048, "R8");

    // R9 undecoded offsets
    rd(12'h018, "R9");
    wr(12'h018, 32'hFFFF_FFFF, "R9");
    rd(12'h03C, "R9");
    rd(12'h001, "R9");
    wr(12'h01D, 32'hFFFF_FFFF, "R9");
    wr(12'h001, 32'hFFFF_FFFF, "R9");
    rd(12'h0A0, "R9");
    rd(12'hFFC, "R9");
    idle("R9");
    rd(12'h034, "R9");
    rd(12'h000, "R9");

    // R10 back-to-back reads
    rd(12'h034, "R10");
    rd(12'h008, "R10");
    rd(12'h038, "R10");
    idle("R10");
    idle("R10");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule